// File: doc/BRIEF.md
# Integer channel to single-precision converter

This block takes one integer channel value per cycle and turns it into a 32-bit word. The word is either an IEEE-754 single-precision number or the integer itself, widened. A format code selects one of six readings of the source. Two are normalized: unsigned, which maps to [0, 1], and signed, which maps to [-1, 1]. Two pass the integer through. Two are scaled, which gives the float equal to the integer. A width code says how many low bits of the input word hold the source. Every float result is correctly rounded to nearest even.

The unit is a three-stage pipeline with a valid flag that travels alongside the data. It has no backpressure, so it can accept a new value on every cycle. A texture or vertex fetch path would place it after the unpack step.

Division by 2^k-1 is done without a divider. For a nonzero k-bit code M, the binary expansion of M/(2^k-1) is M repeated forever. The block builds 64 bits of that repetition and then normalizes and rounds it on the same datapath that the scaled formats use.

Top module: `nint_to_f32`

## Requirements
- R1: A value accepted with in_valid high appears on out_data with out_valid high exactly 3 clock cycles later. out_valid is low in every cycle that does not correspond to an accepted input, and one result can be produced every cycle.
- R2: in_width 0 selects bits [7:0] (n=8), 1 selects bits [15:0] (n=16), and 2 or 3 selects all 32 bits (n=32). Input bits above the selected width do not affect the result.
- R3: in_fmt 0 (unsigned normalized) returns the source divided by 2^n-1, rounded to nearest even single precision. A source of 0 gives 0x00000000 and an all-ones source gives 0x3F800000.
- R4: in_fmt 1 (signed normalized) reads the source as n-bit two's complement and returns it divided by 2^(n-1)-1, rounded to nearest even. A source of 0 gives 0x00000000 and the largest positive code gives 0x3F800000.
- R5: With in_fmt 1, the most negative code -2^(n-1) gives exactly 0xBF800000, the same as the code -(2^(n-1)-1).
- R6: in_fmt 2 (unsigned integer) outputs the source zero-extended to 32 bits.
- R7: in_fmt 3 (signed integer) outputs the source sign-extended to 32 bits.
- R8: in_fmt 4 (unsigned scaled) and in_fmt 5 (signed scaled) output the single-precision value of the unsigned or two's-complement source. Values that need more than 24 significant bits are rounded to nearest even. For example, 16-bit 0xFFFD scaled signed gives 0xC0400000 (-3.0), and 0x01000001 scaled unsigned gives 0x4B800000.
- R9: While rst_n is low, out_valid and out_data are 0.
- R10: in_fmt 6 and 7 are reserved and give out_data 0x00000000 with the normal valid timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value present this cycle |
| in_fmt | input | 3 | Interpretation code (see R3 to R10) |
| in_width | input | 2 | Source width code (see R2) |
| in_data | input | 32 | Source value in the low bits |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 32 | Float bit pattern or widened integer |

## Verification
Every 8-bit code is sent in all six formats, and every 16-bit code is sent in both normalized formats. In each of these, random bits are placed above the selected width. These sweeps tell apart divisor off-by-one errors, wrong repetition periods and round-up decisions. Random 32-bit codes in every format, with gaps in in_valid, exercise the long repeat patterns and the sticky logic of the scaled path, and separate valid-timing faults from data faults. Directed codes pin down the corners: the two encodings of -1.0, exact ones, a tie rounded down to even, an all-ones 32-bit rounding carry, and reserved codes. Expected floats come from real-number division, correctly rounded to single precision by the bench.

// File: rtl/nint_to_f32.sv
module nint_to_f32 #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_fmt,
  input  logic [1:0]    in_width,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int XW = 2 * DW;
  localparam int LZW = $clog2(XW);
  localparam logic [1:0] K_ZERO = 2'd0, K_FLT = 2'd1, K_INT = 2'd2, K_CLAMP = 2'd3;
  localparam logic [8:0] EB_NORM = 9'd126, EB_SCALE = 9'd158;

  function automatic logic [LZW-1:0] lead0(input logic [XW-1:0] v);
    logic [LZW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        hit = 1'b1;
        n = LZW'(XW - 1 - i);
      end
    end
    return n;
  endfunction

  // stage 1: decode and build the bit stream
  logic [DW-1:0] raw, sx, mag, top;
  logic          sfmt, neg, clamp;
  logic [1:0]    kind_c;
  logic          nrm_c;
  logic [8:0]    eb_c;
  logic [XW-1:0] x_c;

  always_comb begin
    case (in_width)
      2'd0: begin
        raw = {24'd0, in_data[7:0]};
        sx  = {{24{in_data[7]}}, in_data[7:0]};
        top = 32'h0000_0080;
      end
      2'd1: begin
        raw = {16'd0, in_data[15:0]};
        sx  = {{16{in_data[15]}}, in_data[15:0]};
        top = 32'h0000_8000;
      end
      default: begin
        raw = in_data;
        sx  = in_data;
        top = 32'h8000_0000;
      end
    endcase
    sfmt  = (in_fmt == 3'd1) || (in_fmt == 3'd3) || (in_fmt == 3'd5);
    neg   = sfmt && sx[DW-1];
    mag   = neg ? (~sx + 1'b1) : raw;
    clamp = (in_fmt == 3'd1) && neg && (mag == top);

    kind_c = K_ZERO;
    nrm_c  = 1'b0;
    eb_c   = '0;
    x_c    = '0;
    case (in_fmt)
      3'd0, 3'd1: begin
        if (clamp) kind_c = K_CLAMP;
        else if (mag != '0) begin
          kind_c = K_FLT;
          nrm_c  = 1'b1;
          eb_c   = EB_NORM;
          if (in_fmt == 3'd0) begin
            case (in_width)
              2'd0:    x_c = {8{mag[7:0]}};
              2'd1:    x_c = {4{mag[15:0]}};
              default: x_c = {2{mag}};
            endcase
          end else begin
            case (in_width)
              2'd0:    x_c = {{9{mag[6:0]}}, mag[6]};
              2'd1:    x_c = {{4{mag[14:0]}}, mag[14:11]};
              default: x_c = {{2{mag[30:0]}}, mag[30:29]};
            endcase
          end
        end
      end
      3'd2: begin
        kind_c = K_INT;
        x_c    = {raw, 32'd0};
      end
      3'd3: begin
        kind_c = K_INT;
        x_c    = {sx, 32'd0};
      end
      3'd4, 3'd5: begin
        if (mag != '0) begin
          kind_c = K_FLT;
          eb_c   = EB_SCALE;
          x_c    = {mag, 32'd0};
        end
      end
      default: kind_c = K_ZERO;
    endcase
  end

  logic          v1, sg1, nrm1;
  logic [1:0]    kind1;
  logic [8:0]    eb1;
  logic [XW-1:0] x1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; sg1 <= 1'b0; nrm1 <= 1'b0; kind1 <= K_ZERO; eb1 <= '0; x1 <= '0;
    end else begin
      v1    <= in_valid;
      sg1   <= neg && (kind_c != K_INT);
      nrm1  <= nrm_c;
      kind1 <= kind_c;
      eb1   <= eb_c;
      x1    <= x_c;
    end
  end

  // stage 2: normalize
  wire [LZW-1:0] lz = (kind1 == K_FLT) ? lead0(x1) : '0;

  logic          v2, sg2, nrm2;
  logic [1:0]    kind2;
  logic [8:0]    e2;
  logic [XW-1:0] x2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; sg2 <= 1'b0; nrm2 <= 1'b0; kind2 <= K_ZERO; e2 <= '0; x2 <= '0;
    end else begin
      v2    <= v1;
      sg2   <= sg1;
      nrm2  <= nrm1;
      kind2 <= kind1;
      e2    <= eb1 - {{(9-LZW){1'b0}}, lz};
      x2    <= x1 << lz;
    end
  end

  // stage 3: round and pack
  wire [23:0] sig  = x2[XW-1 -: 24];
  wire        rb   = x2[XW-25];
  wire        st   = nrm2 | (|x2[XW-26:0]);
  wire        up   = rb & (st | sig[0]);
  wire [24:0] sum  = {1'b0, sig} + {24'd0, up};
  wire [8:0]  ef   = e2 + {8'd0, sum[24]};
  wire [22:0] mant = sum[24] ? 23'd0 : sum[22:0];

  logic [DW-1:0] res;
  always_comb begin
    case (kind2)
      K_FLT:   res = {sg2, ef[7:0], mant};
      K_INT:   res = x2[XW-1 -: DW];
      K_CLAMP: res = 32'hBF80_0000;
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v2;
      out_data  <= res;
    end
  end
endmodule

// File: rtl/nint_to_f32_chk.sv
module nint_to_f32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  in_fmt,
  input logic [1:0]  in_width,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_data
);
  logic [2:0]  hv;
  logic [2:0]  hf [3];
  logic [1:0]  hw [3];
  logic [31:0] hd [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv <= '0;
      for (int i = 0; i < 3; i++) begin
        hf[i] <= '0; hw[i] <= '0; hd[i] <= '0;
      end
    end else begin
      hv <= {hv[1:0], in_valid};
      hf[0] <= in_fmt; hw[0] <= in_width; hd[0] <= in_data;
      for (int i = 1; i < 3; i++) begin
        hf[i] <= hf[i-1]; hw[i] <= hw[i-1]; hd[i] <= hd[i-1];
      end
    end
  end

  wire [31:0] zx = (hw[2] == 2'd0) ? {24'd0, hd[2][7:0]} :
                   (hw[2] == 2'd1) ? {16'd0, hd[2][15:0]} : hd[2];
  wire [31:0] sx = (hw[2] == 2'd0) ? {{24{hd[2][7]}}, hd[2][7:0]} :
                   (hw[2] == 2'd1) ? {{16{hd[2][15]}}, hd[2][15:0]} : hd[2];
  wire [31:0] mn = (hw[2] == 2'd0) ? 32'h80 : (hw[2] == 2'd1) ? 32'h8000 : 32'h8000_0000;
  wire [31:0] al = (hw[2] == 2'd0) ? 32'hFF : (hw[2] == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hv[2]);
  a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hf[2] == 3'd2) |-> out_data == zx);
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hf[2] == 3'd3) |-> out_data == sx);
  a_r5_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hf[2] == 3'd1 && zx == mn) |-> out_data == 32'hBF80_0000);
  a_r3_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hf[2] == 3'd0 && zx == al) |-> out_data == 32'h3F80_0000);
  a_r3_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (hf[2] == 3'd0 || hf[2] == 3'd4)) |-> !out_data[31]);
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hf[2][2:1] == 2'b11) |-> out_data == 32'd0);
endmodule

bind nint_to_f32 nint_to_f32_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
  .in_width(in_width), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/nint_to_f32_tb_top.sv
module nint_to_f32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_fmt = '0;
  logic [1:0]  in_width = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [2:0] vh = '0;
  logic [31:0] q_exp[$];
  logic [31:0] q_in[$];
  string       q_req[$];

  always #5 clk = ~clk;

  nint_to_f32 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_width(in_width), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] to_f32(real r);
    logic [63:0] b;
    logic [52:0] m;
    logic [24:0] s;
    logic        up;
    int          e;
    if (r == 0.0) return 32'd0;
    b  = $realtobits(r);
    m  = {1'b1, b[51:0]};
    e  = int'(b[62:52]) - 1023 + 127;
    up = m[28] & ((|m[27:0]) | m[29]);
    s  = {1'b0, m[52:29]} + {24'd0, up};
    if (s[24]) begin
      e = e + 1;
      s = s >> 1;
    end
    return {b[63], e[7:0], s[22:0]};
  endfunction

  function automatic logic [31:0] model(logic [2:0] f, logic [1:0] w, logic [31:0] d);
    int     n;
    longint u, sv, half;
    n    = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    u    = longint'(d) & ((64'd1 << n) - 1);
    half = 64'd1 << (n - 1);
    sv   = (u >= half) ? u - 2 * half : u;
    case (f)
      3'd0: return (u == 0) ? 32'd0 : to_f32(real'(u) / real'(2 * half - 1));
      3'd1: begin
        if (sv == -half) return 32'hBF80_0000;
        if (sv == 0) return 32'd0;
        return to_f32(real'(sv) / real'(half - 1));
      end
      3'd2: return u[31:0];
      3'd3: return sv[31:0];
      3'd4: return to_f32(real'(u));
      3'd5: return to_f32(real'(sv));
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_out();
    logic [31:0] e, din;
    string r;
    total++;
    if (out_valid !== vh[2]) begin
      bad++;
      $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, vh[2]);
    end
    if (out_valid === 1'b1 && q_exp.size() > 0) begin
      e = q_exp.pop_front(); din = q_in.pop_front(); r = q_req.pop_front();
      total++;
      if (out_data !== e) begin
        bad++;
        $display("FAIL %s in=%h actual=%h expected=%h", r, din, out_data, e);
      end
    end
  endtask

  task automatic step(bit v, logic [2:0] f, logic [1:0] w, logic [31:0] d,
                      logic [31:0] e, string r);
    @(negedge clk);
    check_out();
    in_valid = v; in_fmt = f; in_width = w; in_data = d;
    if (v) begin
      q_exp.push_back(e); q_in.push_back(d); q_req.push_back(r);
    end
    vh = {vh[1:0], v};
  endtask

  task automatic go(logic [2:0] f, logic [1:0] w, logic [31:0] d, string r);
    step(1'b1, f, w, d, model(f, w, d), r);
  endtask

  task automatic lit(logic [2:0] f, logic [1:0] w, logic [31:0] d, logic [31:0] e, string r);
    step(1'b1, f, w, d, e, r);
  endtask

  function automatic string tag(int f);
    case (f)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_data !== 32'd0) begin
      bad++;
      $display("FAIL R9 actual=%b/%h expected=0/00000000", out_valid, out_data);
    end
    rst_n = 1'b1;

    // directed corners
    lit(3'd5, 2'd1, 32'h0000_FFFD, 32'hC040_0000, "R8");
    lit(3'd4, 2'd0, 32'h0000_0003, 32'h4040_0000, "R8");
    lit(3'd4, 2'd2, 32'h0100_0001, 32'h4B80_0000, "R8");
    lit(3'd4, 2'd2, 32'h0100_0003, 32'h4B80_0002, "R8");
    lit(3'd4, 2'd2, 32'hFFFF_FFFF, 32'h4F80_0000, "R8");
    lit(3'd5, 2'd2, 32'h8000_0000, 32'hCF00_0000, "R8");
    lit(3'd1, 2'd0, 32'h0000_0080, 32'hBF80_0000, "R5");
    lit(3'd1, 2'd1, 32'h0000_8000, 32'hBF80_0000, "R5");
    lit(3'd1, 2'd2, 32'h8000_0000, 32'hBF80_0000, "R5");
    lit(3'd1, 2'd0, 32'h0000_0081, 32'hBF80_0000, "R4");
    lit(3'd1, 2'd0, 32'h0000_007F, 32'h3F80_0000, "R4");
    lit(3'd0, 2'd0, 32'h0000_00FF, 32'h3F80_0000, "R3");
    lit(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h3F80_0000, "R3");
    lit(3'd0, 2'd1, 32'h0000_5555, 32'h3EAA_AAAB, "R3");
    lit(3'd0, 2'd1, 32'hABCD_0000, 32'h0000_0000, "R2");
    lit(3'd2, 2'd0, 32'hABCD_EF80, 32'h0000_0080, "R6");
    lit(3'd3, 2'd0, 32'hABCD_EF80, 32'hFFFF_FF80, "R7");
    lit(3'd3, 2'd1, 32'h1234_8000, 32'hFFFF_8000, "R7");
    lit(3'd6, 2'd2, 32'h1234_5678, 32'h0000_0000, "R10");
    lit(3'd7, 2'd0, 32'h0000_00FF, 32'h0000_0000, "R10");

    // every 8-bit code in all formats, random bits above the width (R2)
    for (int f = 0; f < 6; f++)
      for (int x = 0; x < 256; x++)
        go(3'(f), 2'd0, {24'($urandom), 8'(x)}, tag(f));

    // every 16-bit code in both normalized formats
    for (int f = 0; f < 2; f++)
      for (int x = 0; x < 65536; x++)
        go(3'(f), 2'd1, {16'($urandom), 16'(x)}, tag(f));

    // random 32-bit codes per format
    for (int f = 0; f < 6; f++)
      for (int k = 0; k < 1500; k++)
        go(3'(f), 2'(2 + ($urandom % 2)), $urandom, tag(f));

    // mixed random with gaps in in_valid (R1)
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] f;
      logic [1:0] w;
      logic [31:0] d;
      f = 3'($urandom % 8); w = 2'($urandom % 4); d = $urandom;
      if ($urandom % 5 == 0) step(1'b0, f, w, d, 32'd0, "R1");
      else go(f, w, d, tag(int'(f)));
    end

    repeat (5) step(1'b0, 3'd0, 2'd0, 32'd0, 32'd0, "R1");
    total++;
    if (q_exp.size() != 0) begin
      bad++;
      $display("FAIL R1 pending results actual=%0d expected=0", q_exp.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule